// File: doc/BRIEF.md
# Three-Level Page Table Walker with Translation Cache

This block turns a 39-bit virtual address into a 56-bit physical address. It walks a three-level radix page table held in memory. Each table is 4 KB and holds 512 eight-byte entries, so each level uses a 9-bit slice of the virtual address as its index. The walk starts at the root table, whose base comes with the request, and it uses the top index slice first. An entry can stop the walk early as a leaf, which maps a 1 GB or 2 MB region instead of a 4 KB page.

A small fully associative translation cache sits in front of the walker. Every accepted request looks it up first. A hit answers without touching memory. A successful walk writes its result into the cache, choosing the victim in round-robin order. A flush input empties the whole cache in one cycle.

Table entries come in over a single read port that allows one request at a time and any response latency. Each result is returned as a one-cycle response that carries either a physical address with a size code, or a fault.

Top module: `pt_walker`

## Requirements
- R1: A request is accepted when `req_valid_i` and `req_ready_o` are both high. The first table read goes to `{req_root_i[55:12], 12'h000} + 8 * va[38:30]`, so the low 12 bits of the root base are ignored.
- R2: An entry is valid when bit 0 is set. It holds a PPN in bits 53:10. A valid entry with bits 3:1 all clear points to the next table, at `PPN << 12`. The next read goes to that base plus 8 times the next index: `va[29:21]` at the middle level, then `va[20:12]` at the last level.
- R3: An entry is a leaf when any of bits 3:1 (read, write, execute) is set. `rsp_size_o` reports the level of the leaf: 2 means a 1 GB page (root leaf), 1 means a 2 MB page (middle leaf), 0 means a 4 KB page (last-level leaf).
- R4: For a leaf at size code s, the physical address is `PPN << 12`, with its low `12 + 9*s` bits taken from the virtual address. The page offset `va[11:0]` always passes through unchanged.
- R5: An entry with bit 0 clear, met at any level, ends the walk with `rsp_fault_o` high. This holds even when its permission bits are set. No further read is made.
- R6: A valid non-leaf entry at the last level produces a fault.
- R7: A leaf at size code s > 0 whose low `9*s` PPN bits are not all zero is a misaligned large page and produces a fault.
- R8: Each read is a one-cycle pulse on `mem_req_o`. The block then waits any number of cycles for `mem_rvalid_i` before it issues another read, so at most one read is outstanding.
- R9: The cache is searched with the request's virtual page number in the cycle the request is accepted. A hit raises `rsp_valid_o` in the next cycle and makes no memory read. A cached large page matches every address inside its region.
- R10: Every successful walk fills one cache entry. Faults fill nothing. Victims are chosen in round-robin order over the `N_TLB_ENTRIES` entries (4 by default), so the fifth distinct fill evicts the first.
- R11: A cycle with `flush_i` high invalidates every cache entry. A fill in the same cycle is dropped.
- R12: `rsp_valid_o` is high for exactly one cycle per request. `req_ready_o` is high only when no translation is in progress, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all cached translations |
| req_valid_i | input | 1 | Translation request valid |
| req_vaddr_i | input | 39 | Virtual address to translate |
| req_root_i | input | 56 | Physical base of the root table (low 12 bits ignored) |
| req_ready_o | output | 1 | Block is idle and can accept a request |
| mem_req_o | output | 1 | One-cycle read request for a table entry |
| mem_addr_o | output | 56 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Entry returned by memory |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_paddr_o | output | 56 | Translated physical address |
| rsp_size_o | output | 2 | Page size code: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| rsp_fault_o | output | 1 | Translation faulted |

## Verification
The bench sweeps a whole range of last-level slots and changes the read latency between walks. The sweep includes an entry whose permission bits are set but whose valid bit is clear; a design that checked the leaf bits before the valid bit would return an address there instead of a fault. It also covers a pointer met at the last level and large pages at both upper levels with misaligned PPNs. An error in the index slices or the superpage masking would give wrong addresses or wrong fault results. The cache tests do four things: they re-touch addresses inside an already cached 2 MB page, which catches a design that compares all index bits for large pages; they fill past capacity, which catches a wrong round-robin victim through the extra memory reads it causes; they flush between touches; and they raise a flush in the same cycle as a final fill, which catches a design that lets the fill win.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int VA_W    = 39;
  localparam int PA_W    = 56;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 9;
  localparam int LEVELS  = 3;
  localparam int PTE_W   = 64;
  localparam int PPN_LSB = 10;
  localparam int PPN_W   = PA_W - OFF_W;
  localparam int VPN_W   = IDX_W * LEVELS;
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int ENT_SH  = $clog2(PTE_W / 8);

  typedef logic [PPN_W-1:0] ppn_t;
  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_WAIT,
    S_RESP
  } walk_st_e;

  // physical address of a leaf: upper bits from ppn, lower bits from va
  function automatic logic [PA_W-1:0] leaf_paddr(ppn_t ppn, vpn_t vpn,
                                                 logic [OFF_W-1:0] off, lvl_t lvl);
    logic [PA_W-1:0] keep;
    keep = (PA_W'(1) << (OFF_W + IDX_W * int'(lvl))) - PA_W'(1);
    return ({ppn, OFF_W'(0)} & ~keep) | (PA_W'({vpn, off}) & keep);
  endfunction

  function automatic logic ppn_misaligned(ppn_t ppn, lvl_t lvl);
    ppn_t m;
    m = (PPN_W'(1) << (IDX_W * int'(lvl))) - PPN_W'(1);
    return |(ppn & m);
  endfunction

  function automatic logic vpn_match(vpn_t a, vpn_t b, lvl_t lvl);
    vpn_t m;
    m = ~((VPN_W'(1) << (IDX_W * int'(lvl))) - VPN_W'(1));
    return ((a ^ b) & m) == '0;
  endfunction

endpackage

// File: rtl/pt_tlb.sv
module pt_tlb
  import pt_walker_pkg::*;
#(
  parameter int N_ENTRIES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  vpn_t lookup_vpn_i,
  output logic hit_o,
  output ppn_t hit_ppn_o,
  output lvl_t hit_lvl_o,
  input  logic fill_i,
  input  vpn_t fill_vpn_i,
  input  ppn_t fill_ppn_i,
  input  lvl_t fill_lvl_i
);

  localparam int PTR_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [N_ENTRIES-1:0] valid_q;
  logic [N_ENTRIES-1:0] hit_vec;
  vpn_t                 vpn_q [N_ENTRIES];
  ppn_t                 ppn_q [N_ENTRIES];
  lvl_t                 lvl_q [N_ENTRIES];
  logic [PTR_W-1:0]     ptr_q;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = valid_q[e] && vpn_match(vpn_q[e], lookup_vpn_i, lvl_q[e]);
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_ppn_o = '0;
    hit_lvl_o = '0;
    for (int e = N_ENTRIES - 1; e >= 0; e--) begin
      if (hit_vec[e]) begin
        hit_o     = 1'b1;
        hit_ppn_o = ppn_q[e];
        hit_lvl_o = lvl_q[e];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_i) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PTR_W'(N_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !flush_i) begin
      vpn_q[ptr_q] <= fill_vpn_i;
      ppn_q[ptr_q] <= fill_ppn_i;
      lvl_q[ptr_q] <= fill_lvl_i;
    end
  end

  a_r11_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  a_r10_fill_sets_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i) |=> valid_q[$past(ptr_q)]);

  a_r11_flush_holds_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> $stable(ptr_q));

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [PA_W-1:0]   req_root_i,
  output logic              req_ready_o,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output lvl_t              rsp_size_o,
  output logic              rsp_fault_o,
  output vpn_t              tlb_vpn_o,
  input  logic              tlb_hit_i,
  input  ppn_t              tlb_ppn_i,
  input  lvl_t              tlb_lvl_i,
  output logic              fill_o,
  output vpn_t              fill_vpn_o,
  output ppn_t              fill_ppn_o,
  output lvl_t              fill_lvl_o
);

  walk_st_e          state_q;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   base_q;
  lvl_t              lvl_q;
  logic [PA_W-1:0]   pa_q;
  lvl_t              sz_q;
  logic              flt_q;
  logic [IDX_W-1:0]  idx;

  logic pte_v, pte_leaf, pte_misal;
  ppn_t pte_ppn;
  logic unused_bits;

  assign pte_v     = mem_rdata_i[0];
  assign pte_leaf  = |mem_rdata_i[3:1];
  assign pte_ppn   = mem_rdata_i[PPN_LSB +: PPN_W];
  assign pte_misal = (lvl_q != '0) && ppn_misaligned(pte_ppn, lvl_q);
  assign unused_bits = ^{mem_rdata_i[PTE_W-1:PPN_LSB+PPN_W], mem_rdata_i[PPN_LSB-1:4],
                         req_root_i[OFF_W-1:0]};

  always_comb begin
    case (lvl_q)
      2'd2:    idx = va_q[OFF_W + 2*IDX_W +: IDX_W];
      2'd1:    idx = va_q[OFF_W + IDX_W +: IDX_W];
      default: idx = va_q[OFF_W +: IDX_W];
    endcase
  end

  assign mem_addr_o  = base_q + PA_W'({idx, ENT_SH'(0)});
  assign mem_req_o   = (state_q == S_REQ);
  assign req_ready_o = (state_q == S_IDLE);
  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_paddr_o = pa_q;
  assign rsp_size_o  = sz_q;
  assign rsp_fault_o = flt_q;

  assign tlb_vpn_o  = req_vaddr_i[VA_W-1:OFF_W];
  assign fill_o     = (state_q == S_WAIT) && mem_rvalid_i && pte_v && pte_leaf && !pte_misal;
  assign fill_vpn_o = va_q[VA_W-1:OFF_W];
  assign fill_ppn_o = pte_ppn;
  assign fill_lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      pa_q    <= '0;
      sz_q    <= '0;
      flt_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q   <= req_vaddr_i;
          base_q <= {req_root_i[PA_W-1:OFF_W], OFF_W'(0)};
          lvl_q  <= LVL_W'(LEVELS - 1);
          if (tlb_hit_i) begin
            pa_q    <= leaf_paddr(tlb_ppn_i, req_vaddr_i[VA_W-1:OFF_W],
                                  req_vaddr_i[OFF_W-1:0], tlb_lvl_i);
            sz_q    <= tlb_lvl_i;
            flt_q   <= 1'b0;
            state_q <= S_RESP;
          end else begin
            state_q <= S_REQ;
          end
        end
        S_REQ: state_q <= S_WAIT;
        S_WAIT: if (mem_rvalid_i) begin
          if (!pte_v) begin
            flt_q   <= 1'b1;
            pa_q    <= '0;
            state_q <= S_RESP;
          end else if (pte_leaf) begin
            flt_q   <= pte_misal;
            pa_q    <= pte_misal ? '0 : leaf_paddr(pte_ppn, va_q[VA_W-1:OFF_W],
                                                  va_q[OFF_W-1:0], lvl_q);
            sz_q    <= lvl_q;
            state_q <= S_RESP;
          end else if (lvl_q == '0) begin
            flt_q   <= 1'b1;
            pa_q    <= '0;
            state_q <= S_RESP;
          end else begin
            base_q  <= {pte_ppn, OFF_W'(0)};
            lvl_q   <= lvl_q - 1'b1;
            state_q <= S_REQ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r8_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r12_pulse_then_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (req_ready_o && !rsp_valid_o));

  a_r4_offset_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_paddr_o[OFF_W-1:0] == va_q[OFF_W-1:0]));

  a_r9_hit_skips_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && tlb_hit_i) |=> (rsp_valid_o && !mem_req_o));

  a_r5_invalid_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_WAIT) && mem_rvalid_i && !pte_v) |=> (rsp_valid_o && rsp_fault_o));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int N_TLB_ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [PA_W-1:0]   req_root_i,
  output logic              req_ready_o,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic [LVL_W-1:0]  rsp_size_o,
  output logic              rsp_fault_o
);

  vpn_t tlb_vpn, fill_vpn;
  logic tlb_hit, fill;
  ppn_t tlb_ppn, fill_ppn;
  lvl_t tlb_lvl, fill_lvl;

  pt_walk_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_vaddr_i  (req_vaddr_i),
    .req_root_i   (req_root_i),
    .req_ready_o  (req_ready_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_paddr_o  (rsp_paddr_o),
    .rsp_size_o   (rsp_size_o),
    .rsp_fault_o  (rsp_fault_o),
    .tlb_vpn_o    (tlb_vpn),
    .tlb_hit_i    (tlb_hit),
    .tlb_ppn_i    (tlb_ppn),
    .tlb_lvl_i    (tlb_lvl),
    .fill_o       (fill),
    .fill_vpn_o   (fill_vpn),
    .fill_ppn_o   (fill_ppn),
    .fill_lvl_o   (fill_lvl)
  );

  pt_tlb #(.N_ENTRIES(N_TLB_ENTRIES)) u_tlb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .lookup_vpn_i (tlb_vpn),
    .hit_o        (tlb_hit),
    .hit_ppn_o    (tlb_ppn),
    .hit_lvl_o    (tlb_lvl),
    .fill_i       (fill),
    .fill_vpn_i   (fill_vpn),
    .fill_ppn_i   (fill_ppn),
    .fill_lvl_i   (fill_lvl)
  );

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [55:0] ROOT = 56'h8000_0000;
  localparam logic [55:0] MID  = 56'h8000_1000;
  localparam logic [55:0] LEAF = 56'h8000_2000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [38:0] req_vaddr_i = '0;
  logic [55:0] req_root_i = '0;
  logic        req_ready_o;
  logic        mem_req_o;
  logic [55:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        rsp_valid_o;
  logic [55:0] rsp_paddr_o;
  logic [1:0]  rsp_size_o;
  logic        rsp_fault_o;

  pt_walker uut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_root_i(req_root_i),
    .req_ready_o(req_ready_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o),
    .rsp_size_o(rsp_size_o), .rsp_fault_o(rsp_fault_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] mem [logic [55:0]];
  int nchk = 0, nfail = 0, nreads = 0, lat = 0, pend = 0;
  bit done = 0, first_seen = 0, flush_on_resp = 0, fl_drv = 0;
  logic [55:0] first_addr, pend_addr;

  // bench model of cache contents
  bit          cv   [4];
  logic [26:0] cvpn [4];
  logic [43:0] cppn [4];
  logic [1:0]  clv  [4];
  int          cptr = 0;

  function automatic logic [63:0] rd(logic [55:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] mk(logic [43:0] ppn, logic [9:0] flags);
    return {10'd0, ppn, flags};
  endfunction

  function automatic logic [55:0] pa_of(logic [43:0] ppn, logic [38:0] va, int lvl);
    logic [55:0] keep;
    keep = (56'd1 << (12 + 9*lvl)) - 56'd1;
    return ({ppn, 12'h000} & ~keep) | ({17'd0, va} & keep);
  endfunction

  function automatic void ref_walk(input logic [38:0] va, input logic [55:0] root,
                                   output logic [55:0] pa, output logic [1:0] sz,
                                   output bit flt, output int nr);
    logic [55:0] base;
    base = {root[55:12], 12'h000};
    pa = '0; sz = '0; flt = 0; nr = 0;
    for (int lvl = 2; lvl >= 0; lvl--) begin
      logic [63:0] e;
      e = rd(base + {44'd0, va[12 + 9*lvl +: 9], 3'b000});
      nr++;
      if (!e[0]) begin flt = 1; break; end
      if (|e[3:1]) begin
        if (lvl > 0 && ((e[53:10] & ((44'd1 << (9*lvl)) - 44'd1)) != 44'd0)) flt = 1;
        else begin pa = pa_of(e[53:10], va, lvl); sz = 2'(lvl); end
        break;
      end
      if (lvl == 0) begin flt = 1; break; end
      base = {e[53:10], 12'h000};
    end
  endfunction

  function automatic int mlook(logic [26:0] vpn);
    for (int i = 0; i < 4; i++)
      if (cv[i] && (((cvpn[i] ^ vpn) & ~((27'd1 << (9*int'(clv[i]))) - 27'd1)) == 27'd0))
        return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: drives at negedges, latency 1+lat cycles after the request
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      mem_rdata_i  = '0;
      if (fl_drv) begin flush_i = 1'b0; fl_drv = 0; end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = rd(pend_addr);
          if (flush_on_resp) begin flush_i = 1'b1; fl_drv = 1; end
        end
      end else if (rst_ni && mem_req_o) begin
        pend_addr = mem_addr_o;
        nreads++;
        if (!first_seen) begin first_addr = mem_addr_o; first_seen = 1; end
        pend = 1 + lat;
      end
    end
  end

  task automatic run(input logic [38:0] va, input logic [55:0] root, input string tag);
    logic [55:0] epa;
    logic [1:0]  esz;
    bit          eflt, fl;
    int          enr, h, r0, cyc;
    ref_walk(va, root, epa, esz, eflt, enr);
    h  = mlook(va[38:12]);
    fl = flush_on_resp;
    if (h >= 0) begin
      epa = pa_of(cppn[h], va, int'(clv[h])); esz = clv[h]; eflt = 0; enr = 0;
    end
    r0 = nreads;
    first_seen = 0;
    @(negedge clk);
    req_vaddr_i = va; req_root_i = root; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    cyc = 1;
    while (!rsp_valid_o && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(rsp_valid_o, "R12", "response seen", 64'(rsp_valid_o), 64'd1);
    chk(rsp_fault_o == eflt, tag, "fault", 64'(rsp_fault_o), 64'(eflt));
    if (!eflt) begin
      chk(rsp_paddr_o == epa, tag, "paddr", 64'(rsp_paddr_o), 64'(epa));
      chk(rsp_size_o == esz, "R3", "size", 64'(rsp_size_o), 64'(esz));
    end
    chk(nreads - r0 == enr, (h >= 0) ? "R9" : tag, "memory reads",
        64'(nreads - r0), 64'(enr));
    if (enr > 0)
      chk(first_addr == {root[55:12], 12'h000} + {44'd0, va[38:30], 3'b000}, "R1",
          "root read address", 64'(first_addr),
          64'({root[55:12], 12'h000} + {44'd0, va[38:30], 3'b000}));
    if (h >= 0) chk(cyc == 1, "R9", "hit latency", 64'(cyc), 64'd1);
    @(negedge clk);
    chk(!rsp_valid_o && req_ready_o, "R12", "single-cycle response",
        64'({rsp_valid_o, req_ready_o}), 64'b01);
    if (fl) for (int i = 0; i < 4; i++) cv[i] = 0;
    if (h < 0 && !eflt && !fl) begin
      cv[cptr] = 1; cvpn[cptr] = va[38:12]; clv[cptr] = esz;
      cppn[cptr] = rd_leaf_ppn(va, root);
      cptr = (cptr + 1) % 4;
    end
    flush_on_resp = 0;
  endtask

  function automatic logic [43:0] rd_leaf_ppn(logic [38:0] va, logic [55:0] root);
    logic [55:0] base;
    base = {root[55:12], 12'h000};
    for (int lvl = 2; lvl >= 0; lvl--) begin
      logic [63:0] e;
      e = rd(base + {44'd0, va[12 + 9*lvl +: 9], 3'b000});
      if (|e[3:1]) return e[53:10];
      base = {e[53:10], 12'h000};
    end
    return '0;
  endfunction

  task automatic flush_pulse();
    @(negedge clk); flush_i = 1'b1;
    @(negedge clk); flush_i = 1'b0;
    for (int i = 0; i < 4; i++) cv[i] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) cv[i] = 0;
    mem[ROOT + 1*8] = mk(44'hC0000, 10'h00F);   // 1 GB leaf
    mem[ROOT + 2*8] = mk(44'h80001, 10'h001);   // pointer to MID
    mem[ROOT + 3*8] = mk(44'hC0001, 10'h00B);   // misaligned 1 GB
    mem[MID + 3*8]  = mk(44'h12400, 10'h007);   // 2 MB leaf
    mem[MID + 4*8]  = mk(44'h80002, 10'h001);   // pointer to LEAF
    mem[MID + 5*8]  = mk(44'h12401, 10'h003);   // misaligned 2 MB
    mem[MID + 6*8]  = mk(44'h12600, 10'h006);   // perms set, not valid
    for (int k = 0; k < 8; k++) mem[LEAF + 56'(k*8)] = mk(44'h30000 + 44'(k*3), 10'h003);
    mem[LEAF + 8*8] = mk(44'h31000, 10'h00E);   // not valid
    mem[LEAF + 9*8] = mk(44'h80003, 10'h001);   // pointer at last level

    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1, "R12", "ready in reset", 64'(req_ready_o), 64'd1);
    chk(rsp_valid_o == 1'b0, "R12", "no response in reset", 64'(rsp_valid_o), 64'd0);
    chk(mem_req_o == 1'b0, "R8", "no read in reset", 64'(mem_req_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // last-level sweep with varying latency
    for (int k = 0; k < 10; k++) begin
      lat = k % 4;
      run({9'd2, 9'd4, 9'(k), 12'(k*273)}, ROOT, (k < 8) ? "R2" : ((k == 8) ? "R5" : "R6"));
    end
    // hits, then round-robin eviction
    for (int k = 4; k < 8; k++) run({9'd2, 9'd4, 9'(k), 12'h5a5}, ROOT, "R9");
    run({9'd2, 9'd4, 9'd0, 12'h001}, ROOT, "R10");
    run({9'd2, 9'd4, 9'd4, 12'h002}, ROOT, "R10");
    run({9'd2, 9'd4, 9'd5, 12'h003}, ROOT, "R10");
    // 2 MB pages
    lat = 2;
    for (int j = 0; j < 4; j++) run({9'd2, 9'd3, 9'(j*100), 12'(j*997)}, ROOT, "R4");
    // 1 GB pages
    lat = 1;
    run({9'd1, 9'h1ab, 9'h0cd, 12'h321}, ROOT, "R4");
    run({9'd1, 9'h000, 9'h1ff, 12'hfff}, ROOT, "R4");
    // faults
    run({9'd3, 9'h011, 9'h022, 12'h033}, ROOT, "R7");
    run({9'd2, 9'd5, 9'h044, 12'h055}, ROOT, "R7");
    run({9'd2, 9'd6, 9'h066, 12'h077}, ROOT, "R5");
    run({9'd0, 9'h088, 9'h099, 12'h0aa}, ROOT, "R5");
    // flush
    run({9'd1, 9'h1ab, 9'h000, 12'h444}, ROOT, "R9");
    flush_pulse();
    run({9'd1, 9'h1ab, 9'h000, 12'h444}, ROOT, "R11");
    flush_on_resp = 1;
    run({9'd2, 9'd3, 9'h055, 12'h123}, ROOT, "R11");
    run({9'd2, 9'd3, 9'h056, 12'h124}, ROOT, "R11");
    // root base low bits ignored
    lat = 5;
    flush_pulse();
    run({9'd2, 9'd4, 9'd2, 12'habc}, ROOT | 56'h7f8, "R1");
    run({9'd2, 9'd4, 9'd3, 12'h00c}, ROOT | 56'hfff, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule